// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a 64-entry, byte-wide queue placed between a host-facing write/read path and an internal data path. Bytes go in through a valid/ready push port and leave through a show-ahead valid/ready pop port. The block always reports how many bytes it holds. One programmable water level sets both a near-full and a near-empty warning, and each warning has its own enable. An interrupt output is formed from the enabled warnings.

Writes are checked against the fill level. `in_ready` is low only while the queue is full. A cycle with `in_valid` high while `in_ready` is low is a write that cannot be stored. The byte is dropped and a sticky overflow flag is set. Only `flush` clears that flag. On the pop side, `out_valid` is high whenever at least one byte is held, and `out_data` then shows the oldest byte. A cycle with `out_valid` and `out_ready` both high removes that byte. When the queue is empty, `out_data` reads 0x00 and `out_ready` has no effect.

`flush` empties the queue in one clock and resets both storage pointers. It takes priority over a push or pop in the same cycle.

Top module: `alert_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `overflow` is 0, `irq` is 0, `out_valid` is 0, `out_data` is 0x00 and `in_ready` is 1.
- R2: A push accepted without a pop raises `fill_count` by one on the next clock. `in_ready` is 0 exactly when `fill_count` equals 64.
- R3: Bytes leave in the order they were accepted, and `out_data` always shows the oldest held byte.
- R4: While the queue is empty, `out_valid` is 0 and `out_data` is 0x00. A pop attempt then changes neither `fill_count` nor `overflow`.
- R5: A push and a pop in the same cycle with `fill_count` between 1 and 63 leave `fill_count` unchanged and keep the byte order.
- R6: `near_full` is 1 exactly when (64 − `fill_count`) ≤ `level`. It is combinational from the registered count.
- R7: `near_empty` is 1 exactly when `fill_count` ≤ `level`. It is combinational from the registered count.
- R8: `in_valid` while the queue is full drops the byte, leaves `fill_count` at 64 and sets `overflow`. `overflow` then stays 1 through later pushes and pops until a flush.
- R9: `flush` makes `fill_count` 0 and `overflow` 0 on the next clock, winning over a same-cycle push or pop. The next accepted byte is then the first one out.
- R10: `irq` is a register, reset to 0. After each clock it equals (`hi_irq_en` AND `near_full`) OR (`lo_irq_en` AND `near_empty`) as they stood before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the queue and clear overflow |
| in_valid | input | 1 | Push request |
| in_ready | output | 1 | Queue can accept a byte |
| in_data | input | 8 | Byte to push |
| out_valid | output | 1 | Queue holds at least one byte |
| out_ready | input | 1 | Pop request |
| out_data | output | 8 | Oldest byte, 0x00 when empty |
| level | input | 6 | Water level for both warnings |
| hi_irq_en | input | 1 | Near-full interrupt enable |
| lo_irq_en | input | 1 | Near-empty interrupt enable |
| fill_count | output | 7 | Bytes held, 0 to 64 |
| near_full | output | 1 | Near-full warning |
| near_empty | output | 1 | Near-empty warning |
| overflow | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default parameters: depth 64, 8-bit data and a 6-bit water level. These values are small enough to sweep every water level at every fill count from 0 to 64, which covers all 4160 pairs of both warning comparisons, including each threshold edge. A full fill and drain at this depth also reaches both pointer wraps, the drop on a full queue and the combined push-and-pop at the top of the range.

// File: rtl/alert_fifo_pkg.sv
package alert_fifo_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_go,
  input  logic              pop_go,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_go) wr_ptr <= wr_nxt;
      if (pop_go)  rd_ptr <= rd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_go) mem[wr_ptr] <= din;
  end

  assign head = mem[rd_ptr];

  // R9
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0) && (rd_ptr == '0));
endmodule

// File: rtl/afifo_count.sv
module afifo_count
  import alert_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             push_go,
  output logic             pop_go,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic     full;
  fifo_op_e op;

  assign full      = (count == FULL_CNT);
  assign in_ready  = !full;
  assign out_valid = (count != '0);
  assign push_go   = in_valid && !full && !flush;
  assign pop_go    = out_ready && out_valid && !flush;
  assign op        = fifo_op_e'({push_go, pop_go});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: count <= count + ONE;
        OP_POP:  count <= count - ONE;
        default: count <= count;
      endcase
      if (in_valid && full) overflow <= 1'b1;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && !pop_go) |=> count == $past(count) + ONE);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !overflow);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid && !flush) |=>
      (count == '0) && (overflow == $past(overflow)));
endmodule

// File: rtl/afifo_alerts.sv
module afifo_alerts #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [LVL_W-1:0] level,
  input  logic             hi_en,
  input  logic             lo_en,
  output logic             near_full,
  output logic             near_empty,
  output logic             irq
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] cnt_x, lvl_x, free_x;

  assign cnt_x      = {1'b0, count};
  assign lvl_x      = CW'(level);
  assign free_x     = CW'(DEPTH) - cnt_x;
  assign near_full  = (free_x <= lvl_x);
  assign near_empty = (cnt_x <= lvl_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (hi_en && near_full) || (lo_en && near_empty);
  end

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past((hi_en && near_full) || (lo_en && near_empty)));
endmodule

// File: rtl/alert_fifo.sv
module alert_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_data,
  input  logic [LVL_W-1:0]         level,
  input  logic                     hi_irq_en,
  input  logic                     lo_irq_en,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                     near_full,
  output logic                     near_empty,
  output logic                     overflow,
  output logic                     irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push_go, pop_go;
  logic [DATA_W-1:0] head;

  afifo_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .push_go(push_go), .pop_go(pop_go),
    .count(fill_count), .overflow(overflow)
  );

  afifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_go(push_go), .pop_go(pop_go),
    .din(in_data), .head(head)
  );

  afifo_alerts #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_alerts (
    .clk(clk), .rst_n(rst_n), .count(fill_count), .level(level),
    .hi_en(hi_irq_en), .lo_en(lo_irq_en),
    .near_full(near_full), .near_empty(near_empty), .irq(irq)
  );

  assign out_data = out_valid ? head : '0;
endmodule

// File: tb/tb_alert_fifo.sv
module tb_alert_fifo;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int LW    = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, flush, in_valid, in_ready, out_valid, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic [LW-1:0] level;
  logic          hi_irq_en, lo_irq_en, near_full, near_empty, overflow, irq;
  logic [6:0]    fill_count;

  alert_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .LVL_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level(level), .hi_irq_en(hi_irq_en), .lo_irq_en(lo_irq_en),
    .fill_count(fill_count), .near_full(near_full), .near_empty(near_empty),
    .overflow(overflow), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [DW-1:0] q[$];

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(bit pv, logic [DW-1:0] d, bit pr, bit fl);
    @(negedge clk);
    in_valid = pv; in_data = d; out_ready = pr; flush = fl;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0; flush = 1'b0;
  endtask

  task automatic sweep(int c);
    for (int l = 0; l < (1 << LW); l++) begin
      level = LW'(l);
      #1;
      chk("R6 near_full", near_full, ((DEPTH - c) <= l));
      chk("R7 near_empty", near_empty, (c <= l));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; in_valid = 0; in_data = '0; out_ready = 0;
    level = '0; hi_irq_en = 0; lo_irq_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 count", fill_count, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irq", irq, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_data", out_data, 0);
    chk("R1 in_ready", in_ready, 1);

    // R4 pop on empty
    cyc(0, '0, 1, 0);
    chk("R4 count", fill_count, 0);
    chk("R4 overflow", overflow, 0);
    chk("R4 out_valid", out_valid, 0);
    chk("R4 out_data", out_data, 0);

    // fill with full level sweep at each count
    for (int c = 0; c < DEPTH; c++) begin
      logic [DW-1:0] d;
      sweep(c);
      d = DW'((c * 37 + 5) & 255);
      cyc(1, d, 0, 0);
      q.push_back(d);
      chk("R2 count", fill_count, c + 1);
      chk("R2 in_ready", in_ready, (c + 1 < DEPTH));
    end
    sweep(DEPTH);

    // R10 registered interrupt
    @(negedge clk);
    level = '0; hi_irq_en = 1;
    #1;
    chk("R10 irq lag", irq, 0);
    @(negedge clk);
    chk("R10 irq hi", irq, 1);
    hi_irq_en = 0; lo_irq_en = 1;
    @(negedge clk);
    chk("R10 irq lo off", irq, 0);
    lo_irq_en = 0;

    // R8 write while full
    cyc(1, 8'hEE, 0, 0);
    chk("R8 count", fill_count, DEPTH);
    chk("R8 overflow", overflow, 1);
    chk("R3 head", out_data, q[0]);
    cyc(0, '0, 1, 0);
    void'(q.pop_front());
    chk("R8 count after pop", fill_count, DEPTH - 1);
    chk("R8 sticky", overflow, 1);

    // R5 push and pop together
    chk("R5 head", out_data, q[0]);
    cyc(1, 8'h5A, 1, 0);
    void'(q.pop_front());
    q.push_back(8'h5A);
    chk("R5 count", fill_count, DEPTH - 1);

    // R3 drain in order
    while (q.size() > 0) begin
      chk("R3 order", out_data, q[0]);
      cyc(0, '0, 1, 0);
      void'(q.pop_front());
      chk("R3 count", fill_count, q.size());
    end
    chk("R8 sticky empty", overflow, 1);
    chk("R4 empty data", out_data, 0);
    chk("R4 empty valid", out_valid, 0);

    // R10 near-empty interrupt
    @(negedge clk);
    level = '0; lo_irq_en = 1;
    @(negedge clk);
    chk("R10 irq lo", irq, 1);
    lo_irq_en = 0;
    @(negedge clk);
    chk("R10 irq drop", irq, 0);

    // R9 flush beats push and pop
    for (int i = 0; i < 5; i++) cyc(1, DW'(i + 1), 0, 0);
    chk("R2 count five", fill_count, 5);
    cyc(1, 8'h77, 1, 1);
    chk("R9 count", fill_count, 0);
    chk("R9 overflow", overflow, 0);
    chk("R9 out_valid", out_valid, 0);
    cyc(1, 8'h3C, 0, 0);
    chk("R9 first after flush", out_data, 8'h3C);
    chk("R9 count one", fill_count, 1);
    cyc(0, '0, 1, 0);
    chk("R9 count zero", fill_count, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule